// File: doc/BRIEF.md
# Pulse-Density Acceleration Readout Counter

This block reads an acceleration sensor that reports its measurement as a pulse-density stream locked to a reference clock. The block makes that reference clock itself by dividing the system clock, and hands it to the sensor. On every rising edge of the reference clock it samples two signals from the sensor: a direction level and a return-to-zero count pulse. A reference cycle counts as a hit only when both are high. The block sums the hits over a gate window of N reference cycles, where N is a power of two.

When a window closes, the block outputs a signed offset from the zero-acceleration point. That point is a hit on half of the cycles, so the offset is the hit count minus N/2. A one-cycle valid strobe comes with the result. A window in which every cycle, or no cycle, was a hit also raises a saturation flag.

The gate length is given as a base-two exponent on a configuration input. The block latches that exponent at reset and again whenever a window closes. A change to the input therefore never alters the window that is already open. Conversion of the result to units of g is left to downstream logic.

Top module: `pdm_accel_counter`

## Requirements
- R1: `sens_clk_o` is a square wave that stays high for HALF_DIV system cycles and then low for HALF_DIV system cycles. It is held low during reset.
- R2: A reference cycle adds one to the window count only when `sens_dir_i` and `sens_pulse_i` are both high at the rising-edge sample. A pulse without the direction level adds nothing, and the direction level without a pulse adds nothing.
- R3: A window spans 2^L reference cycles. L is the configuration exponent clamped to the range 1 to MAX_LOG2, so an exponent of 0 acts as 1 and any value above MAX_LOG2 acts as MAX_LOG2. Consecutive valid strobes are 2·HALF_DIV·2^L system cycles apart.
- R4: `result_o` is the two's-complement value (hits − 2^(L−1)) on MAX_LOG2+1 bits, where L belongs to the window that just closed.
- R5: `saturated_o` is 1 exactly when the closed window had 0 hits or 2^L hits.
- R6: The block latches `cfg_gate_lg` at the sample that closes a window, and the value then applies to the next window. A value present at that same closing sample is the one taken. Changes in the middle of a window have no effect on that window.
- R7: `valid_o` is high for one system cycle, one cycle after the closing sample. `result_o` and `saturated_o` hold their values until the next window closes.
- R8: Active-low synchronous reset clears the count, drives `valid_o`, `result_o` and `saturated_o` to 0, and latches the exponent. No valid strobe appears until one full window has been sampled after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gate_lg | input | CFG_W | Requested gate exponent L (window = 2^L reference cycles) |
| sens_dir_i | input | 1 | Direction level from the sensor, changes on the reference falling edge |
| sens_pulse_i | input | 1 | Return-to-zero count pulse from the sensor |
| sens_clk_o | output | 1 | Reference clock driven to the sensor |
| result_o | output | MAX_LOG2+1 | Signed offset of the window count from its midpoint |
| saturated_o | output | 1 | Closed window was all hits or no hits |
| valid_o | output | 1 | One-cycle strobe when a new result is presented |

## Verification
Two functions can fall in the same cycle: the closing of a window and a new gate exponent arriving on the configuration input. The bench provokes this by arming a swap, which changes `cfg_gate_lg` at the same negative edge where it sees the closing sample. It then judges the following window by the spacing of the valid strobes and by the midpoint used in the result, and both must follow the new exponent. The bench also changes the exponent in the middle of a window, and it asserts reset part-way through a window. In both cases it checks that the window in progress is either left untouched or discarded.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

  function automatic int window_len(input int lg);
    return 1 << lg;
  endfunction

  function automatic int clamp_lg(input int raw, input int max_lg);
    if (raw < 1) return 1;
    if (raw > max_lg) return max_lg;
    return raw;
  endfunction

  function automatic int centre_offset(input int hits, input int lg);
    return hits - (1 << (lg - 1));
  endfunction

  function automatic logic is_pinned(input int hits, input int lg);
    return (hits == 0) || (hits == (1 << lg));
  endfunction

endpackage

// File: rtl/pdac_refclk.sv
module pdac_refclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_clk_o,
  output logic rise_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          ref_q;
  logic          ref_prev_q;
  logic          div_wrap;

  assign div_wrap  = (div_q == DW'(HALF_DIV - 1));
  assign ref_clk_o = ref_q;
  // sample point: first system cycle after the reference clock rose
  assign rise_o    = ref_q & ~ref_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q      <= '0;
      ref_q      <= 1'b0;
      ref_prev_q <= 1'b0;
    end else begin
      ref_prev_q <= ref_q;
      if (div_wrap) begin
        div_q <= '0;
        ref_q <= ~ref_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R1: the reference clock only moves when the divider wraps
  assert_ref_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !div_wrap |=> $stable(ref_q));

  // R1: a sample strobe never lasts longer than one system cycle
  assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/pdac_window.sv
module pdac_window
  import pdac_pkg::*;
#(
  parameter int MAX_LOG2 = 6,
  parameter int CFG_W    = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sample_i,
  input  logic [CFG_W-1:0]                  cfg_i,
  output logic [$clog2(MAX_LOG2+1)-1:0]     active_lg_o,
  output logic                              last_o
);
  localparam int LW = $clog2(MAX_LOG2 + 1);
  localparam int CW = MAX_LOG2 + 1;

  logic [LW-1:0] lg_q;
  logic [CW-1:0] idx_q;
  logic [LW-1:0] lg_next;
  logic [CW-1:0] len_m1;

  assign lg_next     = LW'(clamp_lg(int'(cfg_i), MAX_LOG2));
  assign len_m1      = CW'(window_len(int'(lg_q)) - 1);
  assign last_o      = sample_i && (idx_q == len_m1);
  assign active_lg_o = lg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lg_q  <= lg_next;
      idx_q <= '0;
    end else if (sample_i) begin
      if (last_o) begin
        idx_q <= '0;
        lg_q  <= lg_next;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R3: the cycle index never passes the end of the active window
  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= len_m1);

  // R6: the active exponent only changes at a window boundary
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !last_o |=> $stable(lg_q));

endmodule

// File: rtl/pdac_accum.sv
module pdac_accum #(
  parameter int MAX_LOG2 = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_i,
  input  logic                  last_i,
  input  logic                  dir_i,
  input  logic                  pulse_i,
  output logic [MAX_LOG2:0]     total_o
);
  localparam int CW = MAX_LOG2 + 1;

  logic [CW-1:0] acc_q;
  logic          hit;

  // a cycle counts only when the pulse is qualified by the direction level
  assign hit     = sample_i & dir_i & pulse_i;
  assign total_o = acc_q + CW'(hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (last_i) begin
      acc_q <= '0;
    end else if (hit) begin
      acc_q <= acc_q + 1'b1;
    end
  end

  // R2: the running count moves only on a reference sample
  assert_acc_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(acc_q));

endmodule

// File: rtl/pdm_accel_counter.sv
module pdm_accel_counter
  import pdac_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int MAX_LOG2 = 6,
  parameter int CFG_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CFG_W-1:0]         cfg_gate_lg,
  input  logic                     sens_dir_i,
  input  logic                     sens_pulse_i,
  output logic                     sens_clk_o,
  output logic signed [MAX_LOG2:0] result_o,
  output logic                     saturated_o,
  output logic                     valid_o
);
  localparam int CW = MAX_LOG2 + 1;
  localparam int LW = $clog2(MAX_LOG2 + 1);

  logic          sample_evt;
  logic          window_close;
  logic [LW-1:0] active_lg;
  logic [CW-1:0] window_total;

  logic                 valid_q;
  logic signed [CW-1:0] res_q;
  logic                 sat_q;

  pdac_refclk #(.HALF_DIV(HALF_DIV)) u_refclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_clk_o (sens_clk_o),
    .rise_o    (sample_evt)
  );

  pdac_window #(.MAX_LOG2(MAX_LOG2), .CFG_W(CFG_W)) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_i    (sample_evt),
    .cfg_i       (cfg_gate_lg),
    .active_lg_o (active_lg),
    .last_o      (window_close)
  );

  pdac_accum #(.MAX_LOG2(MAX_LOG2)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample_evt),
    .last_i   (window_close),
    .dir_i    (sens_dir_i),
    .pulse_i  (sens_pulse_i),
    .total_o  (window_total)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      sat_q   <= 1'b0;
    end else begin
      valid_q <= window_close;
      if (window_close) begin
        res_q <= CW'(centre_offset(int'(window_total), int'(active_lg)));
        sat_q <= is_pinned(int'(window_total), int'(active_lg));
      end
    end
  end

  assign valid_o     = valid_q;
  assign result_o    = res_q;
  assign saturated_o = sat_q;

  // R7: the valid strobe lasts one system cycle
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R7: the result only changes together with a strobe
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(res_q));

  // R5: a saturated window sits a full half-window from the midpoint
  assert_sat_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && sat_q) |->
      ((int'(res_q) == window_len(int'($past(active_lg))) / 2) ||
       (int'(res_q) == -(window_len(int'($past(active_lg))) / 2))));

  // R8: reset clears the presented outputs
  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |=> (!valid_q && res_q == '0 && !sat_q));

endmodule

// File: tb/pdm_accel_counter_bench.sv
module pdm_accel_counter_bench;
  localparam int HALF_DIV = 2;
  localparam int MAX_LOG2 = 6;
  localparam int CFG_W    = 4;
  localparam int CW       = MAX_LOG2 + 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [CFG_W-1:0]     cfg_port = '0;
  logic                 dir_r = 1'b0;
  logic                 pulse_r = 1'b0;
  logic                 sens_clk;
  logic signed [CW-1:0] result;
  logic                 sat;
  logic                 valid;

  int errors = 0;
  int checks = 0;

  pdm_accel_counter #(.HALF_DIV(HALF_DIV), .MAX_LOG2(MAX_LOG2), .CFG_W(CFG_W)) u_pdm_accel_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_gate_lg (cfg_port),
    .sens_dir_i  (dir_r),
    .sens_pulse_i(pulse_r),
    .sens_clk_o  (sens_clk),
    .result_o    (result),
    .saturated_o (sat),
    .valid_o     (valid)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampf(input int v);
    if (v < 1) return 1;
    if (v > MAX_LOG2) return MAX_LOG2;
    return v;
  endfunction

  // stimulus controls
  int req_cfg = 2;
  int mode = 0;
  int swap_cfg = 0;
  bit swap_armed = 0;

  // bench model state
  bit prev_sclk = 0;
  int m_lg = 2, m_idx = 0, m_hits = 0;
  bit exp_pending = 0;
  int exp_res = 0, exp_len = 0;
  bit exp_sat = 0;
  bit exp_swapped = 0, next_swapped = 0;
  bit cur_swapped = 0;
  int win_done = 0, wins_since_reset = 0;
  int cyc = 0, last_valid_cyc = 0;
  bit have_prev_valid = 0;
  int last_res = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit alt = 0;
  int ph_len = 0, r1_checks = 0;
  bit ph_armed = 0;

  function automatic bit pick_dir();
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return alt;
      3: return lfsr[0];
      4: return 1'b1;
      5: return 1'b0;
      default: return (lfsr[2:0] != 3'b000);
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      cfg_port    = CFG_W'(req_cfg);
      m_lg        = clampf(req_cfg);
      m_idx       = 0;
      m_hits      = 0;
      exp_pending = 0;
      prev_sclk   = 0;
      dir_r       = 0;
      pulse_r     = 0;
      have_prev_valid = 0;
      wins_since_reset = 0;
      cur_swapped = 0;
      ph_armed    = 0;
      ph_len      = 0;
      last_res    = 0;
    end else begin
      // output checks for the cycle after a closing sample
      if (exp_pending) begin
        check(valid === 1'b1, "R7 valid strobe", int'(valid), 1);
        check(int'(result) == exp_res, (mode == 4 || mode == 5) ? "R2 gated count" : "R4 result", int'(result), exp_res);
        check(sat == exp_sat, "R5 saturation", int'(sat), int'(exp_sat));
        if (have_prev_valid)
          check(cyc - last_valid_cyc == 2 * HALF_DIV * exp_len, exp_swapped ? "R6 swapped window length" : "R3 window length",
                cyc - last_valid_cyc, 2 * HALF_DIV * exp_len);
        have_prev_valid = 1;
        last_valid_cyc  = cyc;
        last_res        = int'(result);
        exp_pending     = 0;
        win_done++;
        wins_since_reset++;
      end else begin
        if (valid !== 1'b0)
          check(0, (wins_since_reset == 0) ? "R8 early valid" : "R7 stray valid", int'(valid), 0);
        if (int'(result) != last_res)
          check(0, "R7 result hold", int'(result), last_res);
      end

      cfg_port = CFG_W'(req_cfg);

      // R1 phase length of the reference clock
      if (sens_clk != prev_sclk) begin
        if (ph_armed && r1_checks < 16) begin
          check(ph_len == HALF_DIV, "R1 phase length", ph_len, HALF_DIV);
          r1_checks++;
        end
        if (sens_clk) ph_armed = 1;
        ph_len = 1;
      end else begin
        ph_len++;
      end

      if (prev_sclk && !sens_clk) begin
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        alt   = ~alt;
        dir_r = pick_dir();
      end
      if (mode == 5)      pulse_r = sens_clk;
      else if (mode == 4) pulse_r = 1'b0;
      else                pulse_r = sens_clk & dir_r;

      if (sens_clk && !prev_sclk) begin
        if (dir_r && pulse_r) m_hits++;
        m_idx++;
        if (m_idx == (1 << m_lg)) begin
          if (swap_armed) begin
            cfg_port     = CFG_W'(swap_cfg);
            req_cfg      = swap_cfg;
            swap_armed   = 0;
            next_swapped = 1;
          end else begin
            next_swapped = 0;
          end
          exp_res     = m_hits - (1 << (m_lg - 1));
          exp_sat     = (m_hits == 0) || (m_hits == (1 << m_lg));
          exp_len     = 1 << m_lg;
          exp_swapped = cur_swapped;
          cur_swapped = next_swapped;
          exp_pending = 1;
          m_lg   = clampf(int'(cfg_port));
          m_idx  = 0;
          m_hits = 0;
        end
      end
      prev_sclk = sens_clk;
    end
  end

  task automatic wait_windows(input int n);
    int target;
    target = win_done + n;
    while (win_done < target) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0;
    req_cfg = 2;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check(valid === 1'b0, "R8 reset valid", int'(valid), 0);
    check(result === '0, "R8 reset result", int'(result), 0);
    check(sat === 1'b0, "R8 reset sat", int'(sat), 0);
    check(sens_clk === 1'b0, "R1 reset clock low", int'(sens_clk), 0);
    @(posedge clk);
    #1 rst_n = 1;

    // sweep every exponent (including out of range) against every pattern
    for (int lg = 0; lg <= 7; lg++) begin
      for (int md = 0; md <= 6; md++) begin
        mode = md;
        req_cfg = lg;
        wait_windows(2);
      end
    end
    req_cfg = 15;
    mode = 3;
    wait_windows(2);

    // R6: exponent swap at the very sample that closes a window
    req_cfg = 3;
    mode = 6;
    wait_windows(2);
    swap_cfg = 5;
    swap_armed = 1;
    wait_windows(3);
    swap_cfg = 1;
    swap_armed = 1;
    wait_windows(3);

    // R6: mid-window change must leave the open window alone
    req_cfg = 4;
    mode = 2;
    wait_windows(1);
    repeat (10) @(negedge clk);
    req_cfg = 2;
    wait_windows(3);

    // R8: reset in the middle of a window discards it
    req_cfg = 4;
    mode = 1;
    wait_windows(1);
    repeat (20) @(negedge clk);
    @(posedge clk);
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    wait_windows(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule